// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This controller decides which program and erase requests may reach a 2 MiB serial-flash array. The array is made of 32 blocks of 64 KiB each. The controller holds a four-bit protect code and a lock bit. The protect code selects a protected region of the array. That region is a run of blocks counted either from the top of the array or from the bottom, or it is the whole array, or it is nothing.

A command decoder outside the block sends already-decoded request strobes. A status-register write strobe carries a new protect code and a new lock bit. An access strobe carries a kind (program, sector erase, block erase or chip erase) and a 21-bit byte address. For every strobe the controller returns a one-cycle answer on the following clock, either accepted or refused.

The write-protect pin is active low. When the pin is low and the lock bit is set, the status register is frozen. When the pin is high, the lock bit is ignored and the register can always be written.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the protect code reads 0000, the lock bit reads 0, and all four response outputs are low.
- R2: With protect code 0000, every program, sector erase and block erase is granted, and so is a chip erase.
- R3: Protect codes 0001 to 0101 protect the top 1, 2, 4, 8 and 16 blocks in that order. For example, 0001 protects 1F0000h–1FFFFFh and 0101 protects 100000h–1FFFFFh. Requests to the other blocks are granted.
- R4: Protect codes 1010 to 1110 protect the bottom 16, 24, 28, 30 and 31 blocks in that order. For example, 1010 protects 000000h–0FFFFFh and 1110 protects 000000h–1EFFFFh. Requests to the remaining top blocks are granted.
- R5: Protect codes 0110, 0111, 1000, 1001 and 1111 protect every block.
- R6: A chip erase (kind code 3) is granted only when the protect code is 0000, and it is rejected otherwise.
- R7: Each access strobe is answered one clock later by exactly one of grant or reject, held high for one cycle. No answer appears in a cycle that follows no strobe.
- R8: Program (kind 0), sector erase (kind 1) and block erase (kind 2) are judged by the 64 KiB block that holds the address, which is address bits 20:16. Address bits 15:0 have no effect on the answer.
- R9: A status write is committed when the pin is high or the lock bit is 0. The new code and lock bit show on the outputs one clock later, together with a one-cycle accept pulse.
- R10: A status write made while the pin is low and the lock bit is 1 changes neither the code nor the lock bit, and it raises a one-cycle reject pulse.
- R11: With the pin high, a status write is committed even when the lock bit is 1. This includes a write that clears the lock bit.
- R12: An access strobe in the same cycle as a committing status write is judged against the code held before that write. The next access uses the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin_i | input | 1 | Write-protect pin; low arms the lock bit |
| sr_wr_i | input | 1 | Status-register write strobe |
| sr_bp_wdata_i | input | 4 | New protect code for the write |
| sr_lock_wdata_i | input | 1 | New lock bit for the write |
| sr_bp_o | output | 4 | Current protect code |
| sr_lock_o | output | 1 | Current lock bit |
| sr_wr_ok_o | output | 1 | Status write committed (one-cycle pulse) |
| sr_wr_rej_o | output | 1 | Status write refused (one-cycle pulse) |
| acc_req_i | input | 1 | Program/erase request strobe |
| acc_kind_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| acc_addr_i | input | 21 | Byte address of the request |
| acc_grant_o | output | 1 | Request allowed (one-cycle pulse) |
| acc_reject_o | output | 1 | Request denied (one-cycle pulse) |

## Verification
A status-register write and an access request can arrive in the same clock cycle. The access must then be judged against the protect code that was in force before the write. The bench provokes this by raising both strobes together. It writes a code that would open the targeted block, aims the access at a block that the old code protects, and expects a reject alongside the write's accept pulse. It then repeats the same access alone and expects a grant, which shows that the new code applies from the next request.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam int BP_W = 4;

    typedef enum logic [1:0] {
        ACC_PROG       = 2'd0,
        ACC_SECT_ERASE = 2'd1,
        ACC_BLK_ERASE  = 2'd2,
        ACC_CHIP_ERASE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [BP_W-1:0] bp;
        logic            lock;
        logic            wr_ok;
        logic            wr_rej;
    } sr_state_t;

    typedef struct packed {
        logic grant;
        logic reject;
    } acc_resp_t;

endpackage

// File: rtl/wp_range_decode.sv
// Turns the registered protect code into a per-block protection mask.
module wp_range_decode
    import flash_wp_pkg::*;
#(
    parameter int BLK_BITS = 5
) (
    input  logic [BP_W-1:0]          bp_i,
    output logic [(1<<BLK_BITS)-1:0] prot_mask_o
);
    localparam int NBLK     = 1 << BLK_BITS;
    localparam int DN_FIRST = 15 - BLK_BITS;  // first bottom-anchored code

    logic                mode_up, mode_dn, mode_all;
    logic [BLK_BITS:0]   up_first;  // lowest protected block, top-anchored
    logic [BLK_BITS:0]   dn_count;  // protected block count, bottom-anchored

    always_comb begin
        int code;
        code     = int'(bp_i);
        mode_up  = 1'b0;
        mode_dn  = 1'b0;
        mode_all = 1'b0;
        up_first = '0;
        dn_count = '0;
        if (code == 0) begin
            // nothing protected
        end else if (code <= BLK_BITS) begin
            mode_up  = 1'b1;
            up_first = (BLK_BITS+1)'(NBLK - (1 << (code - 1)));
        end else if (code >= DN_FIRST && code <= 14) begin
            mode_dn  = 1'b1;
            dn_count = (BLK_BITS+1)'(NBLK - (1 << (14 - code)));
        end else begin
            mode_all = 1'b1;
        end
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        assign prot_mask_o[g] = mode_all
                              | (mode_up && ((BLK_BITS+1)'(g) >= up_first))
                              | (mode_dn && ((BLK_BITS+1)'(g) <  dn_count));
    end

endmodule

// File: rtl/wp_status_reg.sv
// Protect code and lock bit, with pin/lock gating of writes.
module wp_status_reg
    import flash_wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wp_pin_i,
    input  logic            wr_i,
    input  logic [BP_W-1:0] bp_wdata_i,
    input  logic            lock_wdata_i,
    output logic [BP_W-1:0] bp_o,
    output logic            lock_o,
    output logic            wr_ok_o,
    output logic            wr_rej_o
);
    sr_state_t state_d, state_q;
    logic      frozen;

    always_comb begin
        frozen         = !wp_pin_i && state_q.lock;
        state_d        = state_q;
        state_d.wr_ok  = 1'b0;
        state_d.wr_rej = 1'b0;
        if (wr_i) begin
            if (frozen) begin
                state_d.wr_rej = 1'b1;
            end else begin
                state_d.bp    = bp_wdata_i;
                state_d.lock  = lock_wdata_i;
                state_d.wr_ok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bp_o     = state_q.bp;
    assign lock_o   = state_q.lock;
    assign wr_ok_o  = state_q.wr_ok;
    assign wr_rej_o = state_q.wr_rej;

endmodule

// File: rtl/wp_access_check.sv
// Judges one program/erase request per strobe, answering a cycle later.
module wp_access_check
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int BLK_LSB = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_i,
    input  logic [1:0]                         kind_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [BP_W-1:0]                    bp_i,
    input  logic [(1<<(ADDR_W-BLK_LSB))-1:0]   prot_mask_i,
    output logic                               grant_o,
    output logic                               reject_o
);
    localparam int BLK_BITS = ADDR_W - BLK_LSB;

    acc_resp_t          resp_d, resp_q;
    logic [BLK_BITS-1:0] blk_idx;
    logic               allowed;
    logic               unused_low;

    assign blk_idx    = addr_i[ADDR_W-1:BLK_LSB];
    assign unused_low = ^addr_i[BLK_LSB-1:0];

    always_comb begin
        if (acc_kind_e'(kind_i) == ACC_CHIP_ERASE) allowed = (bp_i == '0);
        else                                       allowed = !prot_mask_i[blk_idx];
        resp_d.grant  = req_i &&  allowed;
        resp_d.reject = req_i && !allowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign grant_o  = resp_q.grant;
    assign reject_o = resp_q.reject;

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int BLK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin_i,
    input  logic              sr_wr_i,
    input  logic [3:0]        sr_bp_wdata_i,
    input  logic              sr_lock_wdata_i,
    output logic [3:0]        sr_bp_o,
    output logic              sr_lock_o,
    output logic              sr_wr_ok_o,
    output logic              sr_wr_rej_o,
    input  logic              acc_req_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic              acc_grant_o,
    output logic              acc_reject_o
);
    localparam int BLK_BITS = ADDR_W - BLK_LSB;
    localparam int NBLK     = 1 << BLK_BITS;

    logic [NBLK-1:0] prot_mask;

    wp_status_reg u_sr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wp_pin_i     (wp_pin_i),
        .wr_i         (sr_wr_i),
        .bp_wdata_i   (sr_bp_wdata_i),
        .lock_wdata_i (sr_lock_wdata_i),
        .bp_o         (sr_bp_o),
        .lock_o       (sr_lock_o),
        .wr_ok_o      (sr_wr_ok_o),
        .wr_rej_o     (sr_wr_rej_o)
    );

    wp_range_decode #(.BLK_BITS(BLK_BITS)) u_dec (
        .bp_i        (sr_bp_o),
        .prot_mask_o (prot_mask)
    );

    wp_access_check #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (acc_req_i),
        .kind_i      (acc_kind_i),
        .addr_i      (acc_addr_i),
        .bp_i        (sr_bp_o),
        .prot_mask_i (prot_mask),
        .grant_o     (acc_grant_o),
        .reject_o    (acc_reject_o)
    );

endmodule

module flash_wp_ctrl_checker #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_pin_i,
    input logic              sr_wr_i,
    input logic [3:0]        sr_bp_wdata_i,
    input logic              sr_lock_wdata_i,
    input logic [3:0]        sr_bp_o,
    input logic              sr_lock_o,
    input logic              sr_wr_ok_o,
    input logic              sr_wr_rej_o,
    input logic              acc_req_i,
    input logic [1:0]        acc_kind_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              acc_grant_o,
    input logic              acc_reject_o
);
    logic all_code;
    assign all_code = (sr_bp_o inside {4'd6, 4'd7, 4'd8, 4'd9, 4'd15});

    // R7: never both answers at once
    a_r7_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_grant_o, acc_reject_o}));

    // R7: every strobe is answered on the next cycle
    a_r7_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req_i |=> (acc_grant_o || acc_reject_o));

    // R7: no answer without a strobe
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req_i |=> !(acc_grant_o || acc_reject_o));

    // R6: chip erase refused under any protection
    a_r6_chip_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && acc_kind_i == 2'd3 && sr_bp_o != 4'd0 && !sr_wr_i) |=> acc_reject_o);

    // R5: all-block codes refuse everything
    a_r5_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && all_code) |=> acc_reject_o);

    // R2: code zero grants everything
    a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && sr_bp_o == 4'd0) |=> acc_grant_o);

    // R9: committed write shows new value with accept pulse
    a_r9_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && (wp_pin_i || !sr_lock_o)) |=>
            (sr_wr_ok_o && !sr_wr_rej_o && sr_bp_o == $past(sr_bp_wdata_i)
             && sr_lock_o == $past(sr_lock_wdata_i)));

    // R10: frozen register refuses and holds
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && !wp_pin_i && sr_lock_o) |=>
            (sr_wr_rej_o && !sr_wr_ok_o && $stable(sr_bp_o) && $stable(sr_lock_o)));

    // R9: without a write nothing in the register moves
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_i |=> ($stable(sr_bp_o) && $stable(sr_lock_o) && !sr_wr_ok_o && !sr_wr_rej_o));

endmodule

bind flash_wp_ctrl flash_wp_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wp_pin_i        (wp_pin_i),
    .sr_wr_i         (sr_wr_i),
    .sr_bp_wdata_i   (sr_bp_wdata_i),
    .sr_lock_wdata_i (sr_lock_wdata_i),
    .sr_bp_o         (sr_bp_o),
    .sr_lock_o       (sr_lock_o),
    .sr_wr_ok_o      (sr_wr_ok_o),
    .sr_wr_rej_o     (sr_wr_rej_o),
    .acc_req_i       (acc_req_i),
    .acc_kind_i      (acc_kind_i),
    .acc_addr_i      (acc_addr_i),
    .acc_grant_o     (acc_grant_o),
    .acc_reject_o    (acc_reject_o)
);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_pin_i = 1'b1;
    logic        sr_wr_i = 1'b0;
    logic [3:0]  sr_bp_wdata_i = '0;
    logic        sr_lock_wdata_i = 1'b0;
    logic [3:0]  sr_bp_o;
    logic        sr_lock_o, sr_wr_ok_o, sr_wr_rej_o;
    logic        acc_req_i = 1'b0;
    logic [1:0]  acc_kind_i = '0;
    logic [20:0] acc_addr_i = '0;
    logic        acc_grant_o, acc_reject_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] cur_bp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wp_ctrl u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // independent model of the protected block range
    function automatic bit exp_prot(input logic [3:0] bp, input int blk);
        int lo, hi;
        case (bp)
            4'd0:  return 1'b0;
            4'd1:  begin lo = 31; hi = 31; end
            4'd2:  begin lo = 30; hi = 31; end
            4'd3:  begin lo = 28; hi = 31; end
            4'd4:  begin lo = 24; hi = 31; end
            4'd5:  begin lo = 16; hi = 31; end
            4'd10: begin lo = 0;  hi = 15; end
            4'd11: begin lo = 0;  hi = 23; end
            4'd12: begin lo = 0;  hi = 27; end
            4'd13: begin lo = 0;  hi = 29; end
            4'd14: begin lo = 0;  hi = 30; end
            default: begin lo = 0; hi = 31; end
        endcase
        return (blk >= lo && blk <= hi);
    endfunction

    // drive one status write, return ok/rej seen on the next cycle
    task automatic sr_write(input logic [3:0] bp, input logic lock, input logic pin,
                            output logic ok, output logic rej);
        @(negedge clk);
        wp_pin_i = pin; sr_wr_i = 1'b1; sr_bp_wdata_i = bp; sr_lock_wdata_i = lock;
        @(negedge clk);
        sr_wr_i = 1'b0;
        ok = sr_wr_ok_o; rej = sr_wr_rej_o;
    endtask

    task automatic access(input logic [1:0] kind, input logic [20:0] addr,
                          output logic g, output logic r);
        @(negedge clk);
        acc_req_i = 1'b1; acc_kind_i = kind; acc_addr_i = addr;
        @(negedge clk);
        acc_req_i = 1'b0;
        g = acc_grant_o; r = acc_reject_o;
    endtask

    task automatic set_code(input logic [3:0] bp, input string req);
        logic ok, rej;
        sr_write(bp, 1'b0, 1'b1, ok, rej);
        chk({req, " write accepted"}, ok, 1);
        chk({req, " code visible"}, sr_bp_o, bp);
        cur_bp = bp;
    endtask

    task automatic t_reset;
        chk("R1 bp reset", sr_bp_o, 0);
        chk("R1 lock reset", sr_lock_o, 0);
        chk("R1 outputs idle", {sr_wr_ok_o, sr_wr_rej_o, acc_grant_o, acc_reject_o}, 0);
    endtask

    task automatic t_open;
        logic g, r;
        set_code(4'd0, "R2");
        access(2'd0, 21'h000123, g, r); chk("R2 program low", g, 1);
        access(2'd2, 21'h1FFFFF, g, r); chk("R2 block erase top", g, 1);
        access(2'd3, 21'h0ABCDE, g, r); chk("R6 chip erase open", g, 1);
        chk("R6 chip erase no reject", r, 0);
    endtask

    // sweep every code over every block (R3 R4 R5 R6)
    task automatic t_sweep;
        logic g, r;
        for (int c = 0; c < 16; c++) begin
            set_code(4'(c), "R9");
            for (int b = 0; b < 32; b++) begin
                logic [1:0] k;
                k = 2'(b % 3);
                access(k, {5'(b), 16'(b * 977)}, g, r);
                if (c >= 1 && c <= 5)
                    chk($sformatf("R3 code %0d blk %0d", c, b), g, !exp_prot(4'(c), b));
                else if (c >= 10 && c <= 14)
                    chk($sformatf("R4 code %0d blk %0d", c, b), g, !exp_prot(4'(c), b));
                else if (c != 0)
                    chk($sformatf("R5 code %0d blk %0d", c, b), r, 1);
                else
                    chk($sformatf("R2 blk %0d", b), g, 1);
                chk("R7 exactly one answer", int'(g) + int'(r), 1);
            end
            access(2'd3, 21'h0, g, r);
            chk($sformatf("R6 chip erase code %0d", c), g, (c == 0));
        end
    endtask

    task automatic t_granularity;
        logic g, r;
        set_code(4'd1, "R8");
        access(2'd0, 21'h1EFFFF, g, r); chk("R8 last byte of blk 30", g, 1);
        access(2'd1, 21'h1F0000, g, r); chk("R8 first byte of blk 31", r, 1);
        access(2'd0, 21'h1FFFFF, g, r); chk("R8 last byte of blk 31", r, 1);
        set_code(4'd10, "R8");
        access(2'd1, 21'h0FFFFF, g, r); chk("R8 top of bottom half", r, 1);
        access(2'd2, 21'h100000, g, r); chk("R8 base of upper half", g, 1);
    endtask

    task automatic t_idle;
        @(negedge clk); @(negedge clk);
        chk("R7 no answer when idle", {acc_grant_o, acc_reject_o}, 0);
    endtask

    task automatic t_lock;
        logic ok, rej;
        sr_write(4'd2, 1'b1, 1'b0, ok, rej);
        chk("R9 pin low lock 0 accepted", ok, 1);
        chk("R9 lock set", sr_lock_o, 1);
        sr_write(4'd0, 1'b0, 1'b0, ok, rej);
        chk("R10 reject pulse", rej, 1);
        chk("R10 no ok pulse", ok, 0);
        chk("R10 code held", sr_bp_o, 2);
        chk("R10 lock held", sr_lock_o, 1);
        @(negedge clk);
        chk("R10 reject is one cycle", sr_wr_rej_o, 0);
        sr_write(4'd7, 1'b1, 1'b1, ok, rej);
        chk("R11 pin high overrides lock", ok, 1);
        chk("R11 code updated", sr_bp_o, 7);
        sr_write(4'd0, 1'b0, 1'b1, ok, rej);
        chk("R11 lock cleared", sr_lock_o, 0);
        chk("R11 code cleared", sr_bp_o, 0);
        cur_bp = 4'd0;
    endtask

    task automatic t_same_cycle;
        set_code(4'd5, "R12");
        @(negedge clk);
        sr_wr_i = 1'b1; sr_bp_wdata_i = 4'd0; sr_lock_wdata_i = 1'b0; wp_pin_i = 1'b1;
        acc_req_i = 1'b1; acc_kind_i = 2'd0; acc_addr_i = 21'h180000;
        @(negedge clk);
        sr_wr_i = 1'b0; acc_req_i = 1'b0;
        chk("R12 judged against old code", acc_reject_o, 1);
        chk("R12 write still committed", sr_wr_ok_o, 1);
        @(negedge clk);
        acc_req_i = 1'b1;
        @(negedge clk);
        acc_req_i = 1'b0;
        chk("R12 next access uses new code", acc_grant_o, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_open;
        t_sweep;
        t_granularity;
        t_idle;
        t_lock;
        t_same_cycle;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule